// File: doc/BRIEF.md
# Timer Compare/Capture Channel

One channel that sits beside a shared up-counting timer. In compare mode it holds a compare value and raises an event flag when the running counter equals that value. When reload is enabled, the same event also raises a DMA request, so the next compare value can be written in without the processor. In capture mode the channel's register becomes read-only. It stores the counter value on a chosen edge of a chosen trigger source and raises the event flag.

A capture that lands while the event flag is still pending replaces the stored value and sets a separate overwrite flag. Software can then tell that a sample was lost. The counter itself and any output shaping are outside this block.

Top module: `cc_channel`

## Requirements
- R1: After reset `ccr_o`, `evt_flag_o`, `ovf_flag_o` and `dma_req_o` are all 0.
- R2: In compare mode (`cap_mode_i`=0) a cycle with `wr_en_i`=1 loads `wr_data_i` into the channel register, visible on `ccr_o` after the next clock edge.
- R3: In compare mode, with `cnt_run_i`=1 and `cnt_i` equal to the register value, `evt_flag_o` is 1 after that clock edge.
- R4: With `dma_en_i`=1 a compare match sets `dma_req_o` at the same edge as the flag. The request stays high until a cycle with `dma_ack_i`=1 clears it. A new match in the acknowledge cycle keeps it set.
- R5: In capture mode (`cap_mode_i`=1) the write port has no effect on `ccr_o`.
- R6: Source select `src_sel_i`: 00 is the external pin, 01 is `sw_trig_i`. The pin passes through a two-flop synchronizer. A pin change set up before clock edge k is captured at edge k+2.
- R7: Edge select `edge_sel_i`: 00 disables capture, 01 selects rising edges, 10 falling edges, 11 both.
- R8: Source codes 10 and 11 are constant low and constant high. Changing between them is seen as a falling or rising edge of the source.
- R9: On a valid trigger edge the register loads the `cnt_i` value of that cycle, and `evt_flag_o` is set at the same clock edge.
- R10: A trigger arriving while `evt_flag_o` is 1 overwrites the register and sets `ovf_flag_o`.
- R11: With `cnt_run_i`=0 neither compare matches nor capture triggers have any effect.
- R12: `clr_w1c_i` bit 0 clears `evt_flag_o` and bit 1 clears `ovf_flag_o`. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared counter value |
| cnt_run_i | input | 1 | Counter is running |
| cap_mode_i | input | 1 | 0 = compare, 1 = capture |
| src_sel_i | input | 2 | Trigger source select |
| edge_sel_i | input | 2 | Trigger edge select |
| ext_i | input | 1 | Asynchronous external trigger pin |
| sw_trig_i | input | 1 | Software trigger level |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | CNT_W | Register write data |
| clr_w1c_i | input | 2 | Write-1-to-clear: bit 0 event, bit 1 overwrite |
| dma_en_i | input | 1 | Enable DMA reload request on compare |
| dma_ack_i | input | 1 | DMA acknowledge |
| ccr_o | output | CNT_W | Compare/capture register value |
| evt_flag_o | output | 1 | Compare or capture event flag |
| ovf_flag_o | output | 1 | Capture overwrite flag |
| dma_req_o | output | 1 | DMA reload request |

## Verification
The embedded properties check, on every cycle, the following behaviours:
- a disabled edge select or a stopped counter never yields a trigger;
- a trigger loads the current count and sets the flag;
- a trigger on a pending flag sets the overwrite flag;
- a set flag survives a simultaneous clear;
- the register holds still in capture mode without a trigger;
- a pending DMA request holds until acknowledged.

Some behaviours only the bench scenarios can show: the exact synchronizer latency from the pin, the meaning of each source and edge code, and the constant-source trick. Another is the interplay of clearing and re-arming across a sequence of edges. The bench compares these against its behavioural model cycle by cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_SW   = 2'b01,
    SRC_LOW  = 2'b10,
    SRC_HIGH = 2'b11
  } cc_src_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cc_edge_e;

  localparam int unsigned FLAG_EVT = 0;
  localparam int unsigned FLAG_OVF = 1;
endpackage

// File: rtl/cc_trig.sv
module cc_trig
  import cc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_i,
  input  logic       sw_trig_i,
  input  logic [1:0] src_sel_i,
  input  logic [1:0] edge_sel_i,
  input  logic       enable_i,
  output logic       trig_o
);
  localparam int unsigned LastStage = SYNC_STAGES - 1;

  logic [LastStage:0] sync_q;
  logic               lvl, lvl_q, rise, fall;
  cc_src_e            src;
  cc_edge_e           edge_mode;

  assign src       = cc_src_e'(src_sel_i);
  assign edge_mode = cc_edge_e'(edge_sel_i);

  // pin synchronizer
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[LastStage-1:0], ext_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ext_i;
      end
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_PIN:  lvl = sync_q[LastStage];
      SRC_SW:   lvl = sw_trig_i;
      SRC_LOW:  lvl = 1'b0;
      default:  lvl = 1'b1;
    endcase
  end

  // level history tracks the selected source at all times
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_comb begin
    unique case (edge_mode)
      EDGE_OFF:  trig_o = 1'b0;
      EDGE_RISE: trig_o = enable_i & rise;
      EDGE_FALL: trig_o = enable_i & fall;
      default:   trig_o = enable_i & (rise | fall);
    endcase
  end

  p_edge_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b00) |-> !trig_o);
endmodule

// File: rtl/cc_flags.sv
module cc_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_evt_i,
  input  logic       cap_trig_i,
  input  logic [1:0] clr_w1c_i,
  output logic       evt_o,
  output logic       ovf_o
);
  import cc_pkg::*;

  logic evt_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (set_evt_i)                 evt_q <= 1'b1;
      else if (clr_w1c_i[FLAG_EVT])  evt_q <= 1'b0;
      // overwrite judged on the flag as it stood before this edge
      if (cap_trig_i && evt_q)       ovf_q <= 1'b1;
      else if (clr_w1c_i[FLAG_OVF])  ovf_q <= 1'b0;
    end
  end

  assign evt_o = evt_q;
  assign ovf_o = ovf_q;

  p_ovf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_trig_i && evt_o) |=> ovf_o);
  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt_i |=> evt_o);
  p_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w1c_i[FLAG_EVT] && !set_evt_i) |=> !evt_o);
endmodule

// File: rtl/cc_dma.sv
module cc_dma (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic dma_en_i,
  input  logic dma_ack_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   req_q <= 1'b0;
    else if (match_i && dma_en_i)  req_q <= 1'b1;
    else if (dma_ack_i)            req_q <= 1'b0;
  end

  assign req_o = req_q;

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !dma_ack_i) |=> req_o);
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_run_i,
  input  logic             cap_mode_i,
  input  logic [1:0]       src_sel_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             ext_i,
  input  logic             sw_trig_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       clr_w1c_i,
  input  logic             dma_en_i,
  input  logic             dma_ack_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             evt_flag_o,
  output logic             ovf_flag_o,
  output logic             dma_req_o
);
  logic [CNT_W-1:0] ccr_q;
  logic             cap_trig, cmp_match;

  cc_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_i),
    .sw_trig_i  (sw_trig_i),
    .src_sel_i  (src_sel_i),
    .edge_sel_i (edge_sel_i),
    .enable_i   (cap_mode_i & cnt_run_i),
    .trig_o     (cap_trig)
  );

  assign cmp_match = !cap_mode_i && cnt_run_i && (cnt_i == ccr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ccr_q <= '0;
    else if (cap_trig)               ccr_q <= cnt_i;
    else if (wr_en_i && !cap_mode_i) ccr_q <= wr_data_i;
  end

  cc_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_evt_i  (cap_trig | cmp_match),
    .cap_trig_i (cap_trig),
    .clr_w1c_i  (clr_w1c_i),
    .evt_o      (evt_flag_o),
    .ovf_o      (ovf_flag_o)
  );

  cc_dma u_dma (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (cmp_match),
    .dma_en_i  (dma_en_i),
    .dma_ack_i (dma_ack_i),
    .req_o     (dma_req_o)
  );

  assign ccr_o = ccr_q;

  p_cap_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_trig |=> (ccr_o == $past(cnt_i)) && evt_flag_o);
  p_cap_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && !cap_trig) |=> $stable(ccr_o));
  p_stopped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_run_i |-> !cap_trig && !cmp_match);
endmodule

// File: tb/tb_cc_channel.sv
module tb_cc_channel;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt = 0, wr_data = 0;
  logic run = 0, cap = 0, ext = 0, sw = 0, wr = 0, dma_en = 0, ack = 0;
  logic [1:0] src = 0, edg = 0, clr = 0;
  logic [W-1:0] ccr;
  logic evt, ovf, req;

  int n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  logic [W-1:0] m_ccr = 0;
  logic m_evt = 0, m_ovf = 0, m_req = 0, m_prev = 0;
  logic pin_q[$] = '{1'b0, 1'b0};

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_run_i(run), .cap_mode_i(cap),
    .src_sel_i(src), .edge_sel_i(edg), .ext_i(ext), .sw_trig_i(sw),
    .wr_en_i(wr), .wr_data_i(wr_data), .clr_w1c_i(clr), .dma_en_i(dma_en),
    .dma_ack_i(ack), .ccr_o(ccr), .evt_flag_o(evt), .ovf_flag_o(ovf), .dma_req_o(req)
  );

  always @(posedge clk) begin
    logic lvl, rise, fall, trig, match, old_evt;
    if (rst_n) begin
      case (src)
        2'd0: lvl = pin_q[0];
        2'd1: lvl = sw;
        2'd2: lvl = 0;
        default: lvl = 1;
      endcase
      rise = lvl && !m_prev;
      fall = !lvl && m_prev;
      m_prev = lvl;
      void'(pin_q.pop_front());
      pin_q.push_back(ext);
      trig = cap && run && ((edg[0] && rise) || (edg[1] && fall));
      match = !cap && run && (cnt == m_ccr);
      old_evt = m_evt;
      if (trig || match) m_evt = 1; else if (clr[0]) m_evt = 0;
      if (trig && old_evt) m_ovf = 1; else if (clr[1]) m_ovf = 0;
      if (match && dma_en) m_req = 1; else if (ack) m_req = 0;
      if (trig) m_ccr = cnt; else if (wr && !cap) m_ccr = wr_data;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && run) cnt <= cnt + 1'b1;
    if (!done) begin
      chk("ccr", ccr, m_ccr);
      chk("evt", evt, m_evt);
      chk("ovf", ovf, m_ovf);
      chk("req", req, m_req);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(logic [1:0] m);
    clr = m; step(); clr = 0;
  endtask

  initial begin
    cur_req = "R1";
    step(3);
    chk("reset ccr", ccr, 0); chk("reset flags", {evt, ovf, req}, 0);
    rst_n = 1; step();
    run = 1; step(2);
    pulse_clr(2'b11);

    cur_req = "R2";
    wr = 1; wr_data = 16'd60; step(); wr = 0; step();
    chk("write readback", ccr, 60);

    cur_req = "R3";
    dma_en = 1;
    while (cnt != 16'd60) step();
    step();
    chk("match flag", evt, 1);

    cur_req = "R4";
    step(3); chk("req held", req, 1);
    ack = 1; step(); ack = 0; step();
    chk("req cleared", req, 0);
    dma_en = 0;

    cur_req = "R12";
    pulse_clr(2'b01); step(); chk("evt cleared", evt, 0);

    cur_req = "R5";
    cap = 1; src = 0; edg = 2'b01; step(2);
    wr = 1; wr_data = 16'hBEEF; step(); wr = 0; step();
    chk("capture ro", ccr, 60);

    cur_req = "R6";
    ext = 1; step(3);
    chk("pin capture flag", evt, 1);

    cur_req = "R10";
    edg = 2'b11; ext = 0; step(4);
    chk("overwrite", ovf, 1);
    pulse_clr(2'b11); step();

    cur_req = "R7";
    edg = 2'b00; ext = 1; step(4); ext = 0; step(4);
    chk("edge off", evt, 0);
    edg = 2'b10; ext = 1; step(4); chk("fall only no rise", evt, 0);
    ext = 0; step(4); chk("fall captured", evt, 1);
    pulse_clr(2'b01);

    cur_req = "R6";
    src = 2'b01; edg = 2'b01; step(2);
    sw = 1; step(2); chk("sw trigger", evt, 1);
    sw = 0; pulse_clr(2'b01); step();

    cur_req = "R8";
    src = 2'b10; step(2);
    src = 2'b11; step(2); chk("const rise", evt, 1);
    pulse_clr(2'b01); src = 2'b10; step(2); chk("const fall ignored", evt, 0);

    cur_req = "R11";
    run = 0; step();
    src = 2'b11; step(2); chk("stopped ignored", evt, 0);
    src = 2'b10; step(); run = 1; step();

    cur_req = "R12";
    src = 2'b11; clr = 2'b01; step(); clr = 0; step();
    chk("set wins", evt, 1);

    cur_req = "R9";
    src = 2'b01; sw = 0; step(2); sw = 1; step(3);
    chk("ovf on pending", ovf, 1);
    pulse_clr(2'b11); step(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule